// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a system watchdog. A counter advances on a slow tick that comes from its own oscillator and enters the bus clock domain through a synchronizer. A 3-bit prescale code selects one of eight timeout lengths, each a power of two. Software must pulse the kick input before the selected length is reached. If it does not, the block raises a one-cycle system-reset request and starts counting again from zero.

A small control register holds three things: the enable, an arming bit that allows the watchdog to be turned off, and the prescale code. Turning the watchdog on takes a single write. Turning it off takes two writes close together. The first write arms the unlock and must also write enable as one. The second write clears enable, and it must arrive while the arming bit is still set. The arming bit clears itself after a fixed number of bus cycles.

Top module: `wdg_top`

## Requirements
- R1: After an asynchronous reset (rst_ni low), the read-back register is 0x00 and no reset request is raised.
- R2: The read-back byte has bits 7:5 at zero, bit 4 for the arming bit, bit 3 for the enable and bits 2:0 for the prescale code. Every write stores wdata[2:0] as the prescale code.
- R3: While enabled, the reset request rises once the count of detected ticks reaches 2^(BASE_LOG2+code). With the default BASE_LOG2 of 14, codes 0 to 7 give 16384 up to 2097152 ticks.
- R4: The reset request lasts exactly one bus cycle. After it, the count restarts from zero.
- R5: A kick clears the count. A kick in the same cycle as an expiry suppresses the request.
- R6: A write with wdata[3]=1 enables the watchdog. A write with wdata[3]=0 leaves the enable unchanged unless the arming bit reads one.
- R7: Only a write with both wdata[4] and wdata[3] at one sets the arming bit. The bit then reads one for exactly 4 bus cycles and clears itself.
- R8: A clearing write that lands on any of the 4 clock edges after the arming write turns the watchdog off. The same write on the 5th edge is ignored.
- R9: While disabled, the count is held at zero and no request is raised. On re-enable, the count starts from zero.
- R10: A change of prescale code applies at once. If the count already meets or exceeds the new limit, the request follows in the next cycle.
- R11: A tick is counted only on its rising edge, after a two-flop synchronizer. A tick input held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low chip reset |
| wdg_tick_i | input | 1 | Free-running watchdog oscillator tick (asynchronous) |
| kick_i | input | 1 | Restart the watchdog count |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read-back |
| sys_rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
The bench places the clearing write on the fourth and on the fifth edge after arming. A design whose window is off by one would either turn off late or stay on when it should turn off. A write that sets only the arming bit is also tried; a design that arms on it would allow a one-write disable. A prescale code lowered below the running count must fire at once; a design using an equality compare would miss the limit and run until the counter wraps. A tick held high must count only once, and every one of the eight timeouts is measured in ticks, so a wrong shift or an off-by-one limit shows up as a count error.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_W   = 8;
  localparam int PS_W    = 3;
  localparam int TOE_BIT = 4;
  localparam int EN_BIT  = 3;

  typedef struct packed {
    logic            toe;
    logic            en;
    logic [PS_W-1:0] ps;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_tick_sync.sv
module wdg_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tick_pulse_o
);
  // sync chain plus one edge-detect stage
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], tick_i};
  end

  assign tick_pulse_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter  int TOE_HOLD = 4,
  localparam int AGE_W    = (TOE_HOLD > 1) ? $clog2(TOE_HOLD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [4:0]    wdata_i,
  output wdg_cfg_t      cfg_o
);
  wdg_cfg_t         cfg_q;
  logic [AGE_W-1:0] age_q;
  logic             arm;

  assign arm = we_i & wdata_i[TOE_BIT] & wdata_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      age_q <= '0;
    end else begin
      if (we_i) begin
        cfg_q.ps <= wdata_i[PS_W-1:0];
        if (wdata_i[EN_BIT])  cfg_q.en <= 1'b1;
        else if (cfg_q.toe)   cfg_q.en <= 1'b0;  // protected clear
      end
      if (arm) begin
        cfg_q.toe <= 1'b1;
        age_q     <= '0;
      end else if (cfg_q.toe) begin
        if (age_q == AGE_W'(TOE_HOLD - 1)) cfg_q.toe <= 1'b0;
        else                               age_q     <= age_q + 1'b1;
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter  int BASE_LOG2 = 14,
  parameter  int PS_W      = 3,
  localparam int NUM_CODES = 1 << PS_W,
  localparam int CNT_W     = BASE_LOG2 + NUM_CODES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            kick_i,
  input  logic            tick_i,
  output logic            req_o
);
  logic [CNT_W-1:0] lim_tab [NUM_CODES];
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             req_q;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(1) << (BASE_LOG2 + g);
  end

  // >= so a lowered limit fires at once
  assign expire = en_i & (cnt_q >= lim_tab[ps_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= expire & ~kick_i;
      if (!en_i || kick_i || expire) cnt_q <= '0;
      else if (tick_i)               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2   = 14,
  parameter int TOE_HOLD    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdg_tick_i,
  input  logic             kick_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             sys_rst_req_o
);
  wdg_cfg_t cfg;
  logic     tick_pulse;
  logic     unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[REG_W-1:TOE_BIT+1];

  wdg_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (wdg_tick_i),
    .tick_pulse_o(tick_pulse)
  );

  wdg_ctrl #(.TOE_HOLD(TOE_HOLD)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i[TOE_BIT:0]),
    .cfg_o  (cfg)
  );

  wdg_counter #(.BASE_LOG2(BASE_LOG2), .PS_W(PS_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg.en),
    .ps_i  (cfg.ps),
    .kick_i(kick_i),
    .tick_i(tick_pulse),
    .req_o (sys_rst_req_o)
  );

  always_comb begin
    cfg_rdata_o              = '0;
    cfg_rdata_o[PS_W-1:0]    = cfg.ps;
    cfg_rdata_o[EN_BIT]      = cfg.en;
    cfg_rdata_o[TOE_BIT]     = cfg.toe;
  end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       kick_i,
  input logic       cfg_we_i,
  input logic [4:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       sys_rst_req_o
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cfg_rdata_o == 8'h00));

  // R2
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:5] == 3'b000);

  // R2
  a_r2_ps_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rdata_o[2:0] == $past(cfg_wdata_i[2:0])));

  // R4
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  // R5
  a_r5_kick_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !sys_rst_req_o);

  // R6
  a_r6_locked_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_wdata_i[3] && !cfg_rdata_o[4] && cfg_rdata_o[3]) |=> cfg_rdata_o[3]);

  // R7
  a_r7_arm_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[4] && !cfg_wdata_i[3] && !cfg_rdata_o[4]) |=> !cfg_rdata_o[4]);

  // R9
  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[3] |=> !sys_rst_req_o);
endmodule

bind wdg_top wdg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .kick_i       (kick_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i[4:0]),
  .cfg_rdata_o  (cfg_rdata_o),
  .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  localparam int B = 4;

  logic       clk = 0, rst_ni = 0, tick = 0, kick = 0, we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       req;

  always #2.5 clk = ~clk;

  wdg_top #(.BASE_LOG2(B)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wdg_tick_i(tick), .kick_i(kick),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .sys_rst_req_o(req)
  );

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int    tick_mode = 0, phase = 0, rises = 0, req_seen = 0;
  bit    done = 0;

  // behavioural reference
  bit       m_en, m_toe, m_req;
  int       m_left;
  bit [2:0] m_ps;
  longint   m_cnt;
  bit       q[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_ni) begin : model
    bit pulse, fire, en_n;
    if (!rst_ni) begin
      m_en = 0; m_toe = 0; m_req = 0; m_left = 0; m_ps = 0; m_cnt = 0;
      q = '{0, 0, 0};
    end else begin
      pulse = q[1] && !q[2];
      fire  = m_en && (m_cnt >= (longint'(1) << (B + m_ps)));
      m_req = fire && !kick;
      if (!m_en || kick || fire) m_cnt = 0;
      else if (pulse)            m_cnt++;
      q.push_front(tick);
      void'(q.pop_back());
      en_n = m_en;
      if (we) begin
        if (wdata[3])   en_n = 1;
        else if (m_toe) en_n = 0;
        m_ps = wdata[2:0];
      end
      if (we && wdata[4] && wdata[3]) begin
        m_toe = 1; m_left = 4;
      end else if (m_toe) begin
        m_left--;
        if (m_left == 0) m_toe = 0;
      end
      m_en = en_n;
    end
  end

  task automatic check(input bit ok, input string r, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (req) req_seen++;
      check(rdata[7:5] == 0,    "R2 reserved", rdata[7:5], 0);
      check(rdata[2:0] == m_ps, "R2 prescale", rdata[2:0], m_ps);
      check(rdata[3] == m_en,   "R6 enable",   rdata[3], m_en);
      check(rdata[4] == m_toe,  "R7 arm bit",  rdata[4], m_toe);
      check(req == m_req,       {tag, " reset request"}, req, m_req);
    end
  end

  initial forever begin
    @(negedge clk);
    phase++;
    case (tick_mode)
      1: begin
        if ((phase % 4) < 2 && !tick) rises++;
        tick = (phase % 4) < 2;
      end
      2: begin
        if (!tick) rises++;
        tick = 1;
      end
      default: tick = 0;
    endcase
  end

  task automatic wr(input logic [7:0] d);
    we = 1; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_kick();
    kick = 1;
    @(negedge clk);
    kick = 0;
  endtask

  task automatic turn_off();
    wr(8'h18);
    wr(8'h00);
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    waitn(4);
    rst_ni = 1;
    waitn(1);
    check(rdata == 8'h00, "R1 reset register", rdata, 0);
    check(req == 0,       "R1 reset request",  req, 0);

    // R3 R4: every code, measured in ticks
    tag = "R3";
    tick_mode = 1;
    for (int c = 0; c < 8; c++) begin
      int lim, r;
      lim = 1 << (B + c);
      turn_off();
      wr(8'h08 | 8'(c));
      rises = 0;
      while (!req) @(negedge clk);
      r = rises;
      check(r >= lim - 1 && r <= lim + 1, "R3 timeout ticks", r, lim);
      @(negedge clk);
      check(req == 0, "R4 pulse width", req, 0);
    end

    // R5: regular kicks keep it quiet
    tag = "R5";
    wr(8'h09);
    req_seen = 0;
    repeat (25) begin
      waitn(60);
      do_kick();
    end
    check(req_seen == 0, "R5 kicked no request", req_seen, 0);
    waitn(200);
    check(req_seen > 0, "R5 request after kicks stop", req_seen, 1);

    // R6 R7: unprotected clear and arm-only write
    tag = "R6";
    wr(8'h0f);
    wr(8'h07);
    check(rdata[3] == 1, "R6 clear ignored", rdata[3], 1);
    wr(8'h17);
    check(rdata[4] == 0, "R7 arm without enable", rdata[4], 0);
    check(rdata[3] == 1, "R7 arm-only keeps enable", rdata[3], 1);

    // R7: arm bit lifetime
    tag = "R7";
    wr(8'h1f);
    for (int i = 0; i < 4; i++) begin
      check(rdata[4] == 1, "R7 arm bit held", rdata[4], 1);
      @(negedge clk);
    end
    check(rdata[4] == 0, "R7 arm bit self-clear", rdata[4], 0);

    // R8: window edges
    tag = "R8";
    wr(8'h1f);
    waitn(4);
    wr(8'h07);
    check(rdata[3] == 1, "R8 fifth edge rejected", rdata[3], 1);
    wr(8'h1f);
    waitn(3);
    wr(8'h07);
    check(rdata[3] == 0, "R8 fourth edge accepted", rdata[3], 0);

    // R9: disabled stays quiet, re-enable starts from zero
    tag = "R9";
    req_seen = 0;
    waitn(3000);
    check(req_seen == 0, "R9 disabled no request", req_seen, 0);
    wr(8'h08);
    rises = 0;
    while (!req) @(negedge clk);
    check(rises >= 15 && rises <= 17, "R9 restart from zero", rises, 16);

    // R10: lowering prescale below the count fires
    tag = "R10";
    wr(8'h0f);
    waitn(400);
    req_seen = 0;
    wr(8'h08);
    waitn(3);
    check(req_seen == 1, "R10 immediate limit", req_seen, 1);

    // R11: held-high tick counts once
    tag = "R11";
    turn_off();
    tick_mode = 2;
    waitn(2);
    wr(8'h08);
    req_seen = 0;
    waitn(500);
    check(req_seen == 0, "R11 held tick counted once", req_seen, 0);
    tick_mode = 0;
    waitn(10);

    summary();
  end
endmodule